// File: doc/BRIEF.md
# Dual-Core Hardware Semaphore Unit

This block gives two processor cores a set of hardware semaphores behind one word-addressed register bus. Every bus access carries a 4-bit core tag on a sideband input. Each semaphore keeps three things: a lock bit, the core tag of its owner and an 8-bit process number of its owner. A core can take a semaphore in one of two ways. It can write the lock register and then read it back to see whether it won. It can also read a separate lock-on-read register, which takes the semaphore atomically in that same access.

Only the recorded owner can release a semaphore, and it must present both its core tag and its process number. A second path releases every semaphore held by one core in a single write. That write must carry a 16-bit key equal to the value held in the key register. When a held semaphore becomes free, the block raises a per-core event bit, provided that core has enabled it. Each core sees the OR of its enabled event bits on its own interrupt line.

Read data comes back registered, one cycle after the request. Lock and unlock accesses always take their core tag from the sideband, never from the write data.

Top module: `hw_semaphore_unit`

## Requirements
- R1: A write to the lock register of semaphore i (word address 0x00+i) with bit 31 = 1, made while that semaphore is free, takes it. The owner is recorded as the sideband core tag and the process number in write bits 7:0. Lock-register reads return {bit 31 lock, bits 11:8 core, bits 7:0 process}, with all other bits 0.
- R2: A lock write to a semaphore that is already held is ignored, whoever makes it.
- R3: A read of the lock-on-read register of semaphore i (word address 0x20+i) behaves as follows:
  - If the semaphore is free, the read takes it with the requester's core tag and process 0, and returns that new state.
  - If the semaphore is held, the read returns the current state and changes nothing.
- R4: Reading a lock register (0x00+i) never changes any semaphore.
- R5: A write to lock register i with bit 31 = 0 frees the semaphore, and clears its recorded IDs to 0, only if both the sideband core tag and the process number (bits 7:0) match the owner. Any other such write leaves the semaphore unchanged.
- R6: A write to the bulk-release register (0x40) carries a key in bits 31:16 and a core tag in bits 11:8. If the key equals the key register, every semaphore owned by that core is freed in the same cycle. If the key differs, nothing changes.
- R7: The key register (0x41) stores write bits 15:0 and reads back as a 16-bit value in bits 15:0. It resets to 0.
- R8: Each core k (0 or 1) has an enable register at 0x44+k and a status register at 0x46+k. Both use bit i for semaphore i.
  - When semaphore i goes from held to free, status bit i of core k is set if enable bit i of core k is 1.
  - Writing 1 to bit i of the clear register at 0x48+k clears that status bit.
- R9: Interrupt output bit k is 1 exactly when core k has some status bit whose enable bit is also set.
- R10: After reset, all semaphores are free with core tag 0 and process 0. The key, enable and status registers are all 0.
- R11: A read request in one cycle gives bus_rvalid = 1 and the read data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_core | input | 4 | Sideband core tag of the requester (0x4 or 0x8) |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq | output | 2 | Per-core interrupt, bit k for core k |

## Verification
The bus carries only one access per cycle. The functions that can still coincide are these:
- A single bulk-release write frees several semaphores in the same edge.
- The same free event sets status bits for both cores at once.

The directed part of the bench gives one core two semaphores and the other core a third. It enables both cores on all of them, then issues a matching-key bulk release. It checks that exactly the owned pair is freed and that both cores' status and interrupt lines reflect the pair together. The random phase mixes lock writes, reads that lock, owner and non-owner unlocks, and bulk releases with right and wrong keys. Every observed read and interrupt value is judged against a bench model.

// File: rtl/hsem_pkg.sv
// Package: shared constants, register map and semaphore state type for the
// dual-core semaphore unit. Assumes a 7-bit word address and 32-bit data.
package hsem_pkg;
    localparam int CORE_W  = 4;
    localparam int PROC_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 7;
    localparam int KEY_W   = 16;
    localparam int N_CORES = 2;

    localparam logic [ADDR_W-1:0] BASE_LOCK  = 7'h00;
    localparam logic [ADDR_W-1:0] BASE_RLOCK = 7'h20;
    localparam logic [ADDR_W-1:0] A_BULK     = 7'h40;
    localparam logic [ADDR_W-1:0] A_KEY      = 7'h41;
    localparam logic [ADDR_W-1:0] BASE_IEN   = 7'h44;
    localparam logic [ADDR_W-1:0] BASE_ISTAT = 7'h46;
    localparam logic [ADDR_W-1:0] BASE_ICLR  = 7'h48;

    typedef struct packed {
        logic              locked;
        logic [CORE_W-1:0] core;
        logic [PROC_W-1:0] proc;
    } sem_state_t;

    // Pack a semaphore state into the lock-register read layout.
    function automatic logic [DATA_W-1:0] pack_sem(input sem_state_t s);
        return {s.locked, 19'b0, s.core, s.proc};
    endfunction
endpackage

// File: rtl/hsem_decode.sv
// Module: address decoder. Turns one bus access into one-hot strobes for the
// semaphore slots and the control registers. Assumes one access per cycle.
module hsem_decode
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 8
) (
    input  logic                      req,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_SEM-1:0]        lock_wr,
    output logic [NUM_SEM-1:0]        rlock_rd,
    output logic                      bulk_wr,
    output logic                      key_wr,
    output logic [N_CORES-1:0]        ien_wr,
    output logic [N_CORES-1:0]        iclr_wr
);
    logic wr_acc;
    logic rd_acc;

    assign wr_acc = req & we;
    assign rd_acc = req & ~we;

    // Per-semaphore strobes.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        assign lock_wr[i]  = wr_acc & (addr == BASE_LOCK  + ADDR_W'(i));
        assign rlock_rd[i] = rd_acc & (addr == BASE_RLOCK + ADDR_W'(i));
    end

    // Per-core control strobes.
    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        assign ien_wr[k]  = wr_acc & (addr == BASE_IEN  + ADDR_W'(k));
        assign iclr_wr[k] = wr_acc & (addr == BASE_ICLR + ADDR_W'(k));
    end

    assign bulk_wr = wr_acc & (addr == A_BULK);
    assign key_wr  = wr_acc & (addr == A_KEY);
endmodule

// File: rtl/hsem_slot.sv
// Module: one semaphore. Holds lock, owner core tag and owner process and
// applies two-step lock, lock-on-read, owner unlock and bulk release.
// Assumes at most one of its strobes is active in a cycle.
module hsem_slot
    import hsem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              lock_bit,
    input  logic              rlock_rd,
    input  logic [CORE_W-1:0] req_core,
    input  logic [PROC_W-1:0] req_proc,
    input  logic              bulk_hit,
    input  logic [CORE_W-1:0] bulk_core,
    output sem_state_t        state,
    output logic              freed
);
    logic take_write;
    logic take_read;
    logic owner_rel;
    logic bulk_rel;

    assign take_write = lock_wr & lock_bit & ~state.locked;
    assign take_read  = rlock_rd & ~state.locked;
    assign owner_rel  = lock_wr & ~lock_bit & state.locked &
                        (state.core == req_core) & (state.proc == req_proc);
    assign bulk_rel   = bulk_hit & state.locked & (state.core == bulk_core);
    assign freed      = owner_rel | bulk_rel;

    // Update ownership on a won lock or an accepted release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (take_write) begin
            state <= '{locked: 1'b1, core: req_core, proc: req_proc};
        end else if (take_read) begin
            state <= '{locked: 1'b1, core: req_core, proc: '0};
        end else if (freed) begin
            state <= '0;
        end
    end
endmodule

// File: rtl/hsem_irq.sv
// Module: per-core free-event logic: enable and status bits per semaphore,
// write-one-to-clear, and one interrupt line per core.
module hsem_irq
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_CORES-1:0]               ien_wr,
    input  logic [N_CORES-1:0]               iclr_wr,
    input  logic [NUM_SEM-1:0]               wmask,
    input  logic [NUM_SEM-1:0]               freed,
    output logic [N_CORES-1:0][NUM_SEM-1:0]  en,
    output logic [N_CORES-1:0][NUM_SEM-1:0]  stat,
    output logic [N_CORES-1:0]               irq
);
    for (genvar k = 0; k < N_CORES; k++) begin : g_core
        // Enable register for core k.
        always_ff @(posedge clk) begin
            if (!rst_n)         en[k] <= '0;
            else if (ien_wr[k]) en[k] <= wmask;
        end

        // Status register for core k: set on free event, clear on write-one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat[k] <= '0;
            end else begin
                stat[k] <= (stat[k] & ~(iclr_wr[k] ? wmask : '0)) | (freed & en[k]);
            end
        end

        assign irq[k] = |(stat[k] & en[k]);
    end
endmodule

// File: rtl/hw_semaphore_unit.sv
// Module: top of the dual-core semaphore unit. Decodes the bus, holds the
// semaphore slots, the key and the per-core event logic, and returns
// registered read data. Assumes one access per cycle and a sideband core tag.
module hw_semaphore_unit
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [6:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_core,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [1:0]        irq
);
    logic [NUM_SEM-1:0]              lock_wr;
    logic [NUM_SEM-1:0]              rlock_rd;
    logic                            bulk_wr;
    logic                            key_wr;
    logic [N_CORES-1:0]              ien_wr;
    logic [N_CORES-1:0]              iclr_wr;
    logic [KEY_W-1:0]                key;
    logic                            bulk_hit;
    sem_state_t                      sem_st [NUM_SEM];
    logic [NUM_SEM-1:0]              sem_locked;
    logic [NUM_SEM-1:0]              freed;
    logic [N_CORES-1:0][NUM_SEM-1:0] en;
    logic [N_CORES-1:0][NUM_SEM-1:0] stat;
    logic [DATA_W-1:0]               rd_next;
    sem_state_t                      taken_st;

    hsem_decode #(.NUM_SEM(NUM_SEM)) u_dec (
        .req      (bus_req),
        .we       (bus_we),
        .addr     (bus_addr),
        .lock_wr  (lock_wr),
        .rlock_rd (rlock_rd),
        .bulk_wr  (bulk_wr),
        .key_wr   (key_wr),
        .ien_wr   (ien_wr),
        .iclr_wr  (iclr_wr)
    );

    assign bulk_hit = bulk_wr & (bus_wdata[31:16] == key);

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_slot
        hsem_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .lock_wr   (lock_wr[i]),
            .lock_bit  (bus_wdata[31]),
            .rlock_rd  (rlock_rd[i]),
            .req_core  (bus_core),
            .req_proc  (bus_wdata[7:0]),
            .bulk_hit  (bulk_hit),
            .bulk_core (bus_wdata[11:8]),
            .state     (sem_st[i]),
            .freed     (freed[i])
        );
        assign sem_locked[i] = sem_st[i].locked;
    end

    hsem_irq #(.NUM_SEM(NUM_SEM)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (ien_wr),
        .iclr_wr (iclr_wr),
        .wmask   (bus_wdata[NUM_SEM-1:0]),
        .freed   (freed),
        .en      (en),
        .stat    (stat),
        .irq     (irq)
    );

    // Key register.
    always_ff @(posedge clk) begin
        if (!rst_n)      key <= '0;
        else if (key_wr) key <= bus_wdata[15:0];
    end

    assign taken_st = '{locked: 1'b1, core: bus_core, proc: '0};

    // Read multiplexer; lock-on-read returns the state after the access.
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (bus_addr == BASE_LOCK + ADDR_W'(i)) rd_next = pack_sem(sem_st[i]);
            if (bus_addr == BASE_RLOCK + ADDR_W'(i))
                rd_next = sem_st[i].locked ? pack_sem(sem_st[i]) : pack_sem(taken_st);
        end
        for (int k = 0; k < N_CORES; k++) begin
            if (bus_addr == BASE_IEN + ADDR_W'(k))   rd_next = DATA_W'(en[k]);
            if (bus_addr == BASE_ISTAT + ADDR_W'(k)) rd_next = DATA_W'(stat[k]);
        end
        if (bus_addr == A_KEY) rd_next = DATA_W'(key);
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_req & ~bus_we;
            if (bus_req && !bus_we) bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/hsem_checker.sv
// Module: property checker for the semaphore unit, bound to the top module.
module hsem_checker
    import hsem_pkg::*;
#(
    parameter int NUM_SEM = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_req,
    input logic                             bus_we,
    input logic [6:0]                       bus_addr,
    input logic [31:0]                      bus_wdata,
    input logic                             bus_rvalid,
    input logic [KEY_W-1:0]                 key,
    input logic [NUM_SEM-1:0]               sem_locked,
    input logic [NUM_SEM-1:0]               freed,
    input logic [N_CORES-1:0][NUM_SEM-1:0]  en,
    input logic [N_CORES-1:0][NUM_SEM-1:0]  stat
);
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        AST_FREE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            freed[i] |-> sem_locked[i]); // R5
        AST_FREE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            freed[i] |=> !sem_locked[i]); // R5
        AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (sem_locked[i] && !freed[i]) |=> sem_locked[i]); // R2
        for (genvar k = 0; k < N_CORES; k++) begin : g_core
            AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
                (freed[i] && en[k][i]) |=> stat[k][i]); // R8
        end
    end

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid); // R11

    AST_BAD_KEY_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == A_BULK && bus_wdata[31:16] != key)
        |=> $stable(sem_locked)); // R6
endmodule

bind hw_semaphore_unit hsem_checker #(.NUM_SEM(NUM_SEM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .key        (key),
    .sem_locked (sem_locked),
    .freed      (freed),
    .en         (en),
    .stat       (stat)
);

// File: tb/test_hw_semaphore_unit.sv
`timescale 1ns/1ps
module test_hw_semaphore_unit;
    localparam int NS = 8;
    localparam logic [3:0] CA = 4'h4;
    localparam logic [3:0] CB = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_core = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    // Bench model of the block's state.
    logic          m_l [NS];
    logic [3:0]    m_c [NS];
    logic [7:0]    m_p [NS];
    logic [15:0]   m_key;
    logic [NS-1:0] m_en [2];
    logic [NS-1:0] m_st [2];

    always #2.5 clk = ~clk;

    hw_semaphore_unit #(.NUM_SEM(NS)) i_hw_semaphore_unit (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
    );

    function automatic logic [31:0] pk(logic l, logic [3:0] c, logic [7:0] p);
        return {l, 19'b0, c, p};
    endfunction

    function automatic logic [1:0] exp_irq();
        return {|(m_st[1] & m_en[1]), |(m_st[0] & m_en[0])};
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin m_l[i] = 0; m_c[i] = 0; m_p[i] = 0; end
        m_key = 0;
        for (int k = 0; k < 2; k++) begin m_en[k] = 0; m_st[k] = 0; end
    endtask

    task automatic model_free(input int i);
        m_l[i] = 0; m_c[i] = 0; m_p[i] = 0;
        for (int k = 0; k < 2; k++) if (m_en[k][i]) m_st[k][i] = 1'b1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] c);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_core = c;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [3:0] c, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a; bus_core = c;
        @(negedge clk);
        bus_req = 0;
        d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic lock_write(input int i, input logic [3:0] c, input logic [7:0] p, input logic lb);
        wr(7'(i), {lb, 23'b0, p}, c);
        if (lb && !m_l[i]) begin m_l[i] = 1; m_c[i] = c; m_p[i] = p; end
        else if (!lb && m_l[i] && m_c[i] == c && m_p[i] == p) model_free(i);
    endtask

    task automatic read_lock(input int i, input logic [3:0] c, input string rq);
        logic [31:0] d; logic v; logic [31:0] e;
        if (!m_l[i]) begin m_l[i] = 1; m_c[i] = c; m_p[i] = 0; end
        e = pk(m_l[i], m_c[i], m_p[i]);
        rd(7'h20 + 7'(i), c, d, v);
        check(rq, d, e);
    endtask

    task automatic read_sem(input int i, input string rq);
        logic [31:0] d; logic v;
        rd(7'(i), CA, d, v);
        check(rq, d, pk(m_l[i], m_c[i], m_p[i]));
    endtask

    task automatic bulk(input logic [3:0] c, input logic [15:0] k);
        wr(7'h40, {k, 4'b0, c, 8'b0}, CB);
        if (k == m_key)
            for (int i = 0; i < NS; i++) if (m_l[i] && m_c[i] == c) model_free(i);
    endtask

    task automatic set_en(input int k, input logic [NS-1:0] m);
        wr(7'h44 + 7'(k), 32'(m), CA); m_en[k] = m;
    endtask

    task automatic clr_st(input int k, input logic [NS-1:0] m);
        wr(7'h48 + 7'(k), 32'(m), CA); m_st[k] = m_st[k] & ~m;
    endtask

    task automatic check_status(input string rq);
        logic [31:0] d; logic v;
        for (int k = 0; k < 2; k++) begin
            rd(7'h46 + 7'(k), CA, d, v);
            check(rq, d, 32'(m_st[k]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d; logic v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10: reset state
        check("R10 irq", 32'(irq), 0);
        for (int i = 0; i < NS; i++) read_sem(i, "R10 sem");
        rd(7'h41, CA, d, v); check("R10/R7 key reset", d, 0);
        check_status("R10 status");

        // R11: response timing
        @(negedge clk); bus_req = 1; bus_we = 0; bus_addr = 7'h41; bus_core = CA;
        @(negedge clk); bus_req = 0;
        check("R11 rvalid after read", 32'(bus_rvalid), 1);
        @(negedge clk); check("R11 rvalid drops", 32'(bus_rvalid), 0);

        // R7: key register
        wr(7'h41, 32'hFFFF_BEEF, CA); m_key = 16'hBEEF;
        rd(7'h41, CB, d, v); check("R7 key readback", d, 32'h0000_BEEF);

        // R1 / R2: two-step lock
        lock_write(0, CA, 8'h12, 1); read_sem(0, "R1 two-step lock");
        lock_write(0, CB, 8'h34, 1); read_sem(0, "R2 other core ignored");
        lock_write(0, CA, 8'h35, 1); read_sem(0, "R2 other process ignored");

        // R4: plain read has no effect
        read_sem(3, "R4 first read"); read_sem(3, "R4 still free");

        // R3: lock-on-read
        read_lock(3, CB, "R3 take free");
        read_sem(3, "R3 state after take");
        read_lock(3, CA, "R3 held no change");
        read_sem(3, "R3 unchanged");

        // R5: protected unlock, R8/R9 event
        set_en(0, 8'h01); set_en(1, 8'h01);
        lock_write(0, CB, 8'h12, 0); read_sem(0, "R5 wrong core");
        lock_write(0, CA, 8'h13, 0); read_sem(0, "R5 wrong process");
        check("R9 irq idle", 32'(irq), 32'(exp_irq()));
        lock_write(0, CA, 8'h12, 0); read_sem(0, "R5 owner unlock");
        check("R9 irq both cores", 32'(irq), 32'b11);
        check_status("R8 status set");
        clr_st(0, 8'h01);
        check("R9 irq after clear", 32'(irq), 32'b10);
        check_status("R8 write one clear");
        clr_st(1, 8'hFF);

        // R6: bulk release, two frees in one cycle
        lock_write(1, CA, 8'h01, 1); lock_write(2, CA, 8'h02, 1);
        set_en(0, 8'h0E); set_en(1, 8'h0E);
        bulk(CA, 16'hBEEE);
        for (int i = 0; i < 4; i++) read_sem(i, "R6 wrong key");
        check("R6 irq wrong key", 32'(irq), 0);
        bulk(CA, 16'hBEEF);
        for (int i = 0; i < 4; i++) read_sem(i, "R6 bulk release");
        check_status("R6/R8 bulk events both cores");
        check("R9 irq after bulk", 32'(irq), 32'(exp_irq()));
        clr_st(0, '1); clr_st(1, '1);

        // Random phase
        void'($urandom(32'd20251));
        for (int n = 0; n < 600; n++) begin
            int op; int s; logic [3:0] c; logic [7:0] p;
            op = int'($urandom % 9);
            s  = int'($urandom % NS);
            c  = ($urandom % 2 == 0) ? CA : CB;
            p  = 8'($urandom % 4);
            case (op)
                0, 1: lock_write(s, c, p, 1);
                2: begin
                    if ($urandom % 2 == 0 && m_l[s]) lock_write(s, m_c[s], m_p[s], 0);
                    else lock_write(s, c, p, 0);
                end
                3: read_lock(s, c, "R3 random");
                4: read_sem(s, "R1/R4 random");
                5: bulk(c, ($urandom % 4 != 0) ? m_key : 16'(m_key + 1));
                6: set_en(int'($urandom % 2), NS'($urandom));
                7: clr_st(int'($urandom % 2), NS'($urandom));
                default: begin
                    logic [15:0] k = 16'($urandom % 3);
                    wr(7'h41, 32'(k), c); m_key = k;
                end
            endcase
            check("R9 random irq", 32'(irq), 32'(exp_irq()));
            if (n % 50 == 0) check_status("R8 random status");
        end
        for (int i = 0; i < NS; i++) read_sem(i, "R1 final state");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule